// File: doc/BRIEF.md
# Overflow Event Timer

This block is a 32-bit up-counter used to raise timed events. Software programs a starting count and starts the counter; it advances by one on every clock while running and raises an overflow event when it passes the all-ones value. To wait N ticks, software writes the value all-ones minus N. The event sets a sticky status flag. The flag drives the interrupt output when its enable bit is set, and software clears it by writing a one.

In one-shot operation the counter halts at the wrap and its run bit clears itself. In periodic operation the counter takes the value of a separate reload register at each wrap and keeps running. For a periodic tick, software first writes the reload register alone and then writes the count and the start bits.

The counter's clock domain is not modelled as a separate clock. Instead, a mode bit can make writes to the control, reload and count registers "posted". A posted write is acknowledged at once, takes effect a fixed three clocks later, and a pending register shows which of those writes are still in flight.

Top module: `up_event_timer`

## Requirements
- R1: While the run bit is set, the count rises by exactly one on each clock. While it is clear, the count holds its value. Reading the count register (offset 2) returns the live value and does not disturb the sequence.
- R2: After reset, every register reads zero: control (0), reload (1), count (2), status (3), enable (4), pending (5) and mode (6). The interrupt output is low.
- R3: Control bit 1 selects periodic mode. When a running periodic counter wraps past all-ones, it takes the reload value, stays running and sets status bit 0.
- R4: When bit 1 is clear (one-shot mode) and a running counter wraps, the count becomes zero, control bit 0 (run) reads back clear, and status bit 0 is set.
- R5: When mode bit 0 is one (posted), a write to control, reload or count takes effect at the third clock edge after the edge that accepted it. Until then, a read returns the old value and pending bit 0, 1 or 2 (control, reload, count) reads one. The pending bit drops when the write lands.
- R6: When mode bit 0 is zero, those writes take effect at the accepting edge and the pending register stays zero.
- R7: Writing status with bit 0 set clears the overflow flag. Writing zero leaves it unchanged. Writes to status and enable always take effect at once.
- R8: The interrupt output is high exactly when status bit 0 and enable bit 0 are both one.
- R9: If the run bit is cleared before the counter reaches all-ones, no overflow flag is raised and the count stops.
- R10: When the count is loaded with all-ones minus N and the counter is started, status bit 0 sets on the (N+1)th counting edge after the run bit takes effect.
- R11: A second posted write to a register whose earlier write is still pending replaces the data and restarts the three-clock delay. The earlier value is never applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus access valid this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register offset |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data for req_addr (combinational) |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions check on every cycle that the count steps by one or holds, that a wrap reloads or halts according to the mode, that the flag only rises while the counter runs, and that a posted control write raises its pending bit.

Only the bench scenarios can show the exact cycle on which a posted write lands and how a rewrite restarts the delay. The same holds for the tick count between start and event, for the one-write-to-clear flag as seen by software, and for the register reads that miss an in-flight write.

// File: rtl/evt_timer_pkg.sv
// Shared constants for the overflow event timer: register offsets,
// control bit positions and the indices of the posted write slots.
// Assumes a word-indexed 3-bit register address.
package evt_timer_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] REG_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] REG_LOAD  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_COUNT = 3'd2;
    localparam logic [ADDR_W-1:0] REG_STAT  = 3'd3;
    localparam logic [ADDR_W-1:0] REG_IEN   = 3'd4;
    localparam logic [ADDR_W-1:0] REG_PEND  = 3'd5;
    localparam logic [ADDR_W-1:0] REG_MODE  = 3'd6;

    // Posted slots; slot i serves the register at offset i.
    localparam int NUM_SLOTS  = 3;
    localparam int SLOT_CTRL  = 0;
    localparam int SLOT_LOAD  = 1;
    localparam int SLOT_COUNT = 2;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_AUTO_BIT = 1;
endpackage

// File: rtl/timer_post_slot.sv
// One posted write slot. In posted mode, a write is held for SYNC_DLY
// clocks and then presented on apply_o for one cycle. A rewrite while it
// is pending replaces the data and restarts the delay. In direct mode the
// write passes straight through in the accepting cycle.
// Assumes SYNC_DLY >= 1.
module timer_post_slot #(
    parameter int DATA_W   = 32,
    parameter int SYNC_DLY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              posted_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              apply_o,
    output logic [DATA_W-1:0] data_o,
    output logic              pend_o
);
    localparam int CNT_W = $clog2(SYNC_DLY + 1);

    logic [CNT_W-1:0]  dly_q;
    logic [DATA_W-1:0] hold_q;

    // Track the in-flight write: load the delay on a posted write, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q  <= '0;
            hold_q <= '0;
        end else if (wr_i && posted_i) begin
            dly_q  <= CNT_W'(SYNC_DLY);
            hold_q <= wdata_i;
        end else if (dly_q != '0) begin
            dly_q <= dly_q - CNT_W'(1);
        end
    end

    // Present the write to the timer state, either delayed or direct.
    always_comb begin
        if (posted_i) begin
            apply_o = (dly_q == CNT_W'(1)) && !wr_i;
            data_o  = hold_q;
        end else begin
            apply_o = wr_i;
            data_o  = wdata_i;
        end
    end

    assign pend_o = (dly_q != '0);
endmodule

// File: rtl/timer_counter.sv
// Counter core: run/periodic control bits, reload register and the
// up-counter. It produces a one-cycle overflow pulse when a running count
// wraps past all-ones. A count write in the same cycle wins over counting.
module timer_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_apply_i,
    input  logic [DATA_W-1:0] ctrl_data_i,
    input  logic              load_apply_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              count_apply_i,
    input  logic [DATA_W-1:0] count_data_i,
    output logic              run_o,
    output logic              auto_o,
    output logic [DATA_W-1:0] load_o,
    output logic [DATA_W-1:0] count_o,
    output logic              ovf_o
);
    import evt_timer_pkg::*;

    logic              run_q;
    logic              auto_q;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] count_q;
    logic              at_max;

    assign at_max = (count_q == {DATA_W{1'b1}});
    assign ovf_o  = run_q && at_max && !count_apply_i;

    // Control bits: software write first, else one-shot self-clear on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            auto_q <= 1'b0;
        end else if (ctrl_apply_i) begin
            run_q  <= ctrl_data_i[CTRL_RUN_BIT];
            auto_q <= ctrl_data_i[CTRL_AUTO_BIT];
        end else if (ovf_o && !auto_q) begin
            run_q <= 1'b0;
        end
    end

    // Reload register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
        end else if (load_apply_i) begin
            load_q <= load_data_i;
        end
    end

    // Count: software write, else step, reload or wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (count_apply_i) begin
            count_q <= count_data_i;
        end else if (run_q) begin
            if (at_max) begin
                count_q <= auto_q ? load_q : '0;
            end else begin
                count_q <= count_q + DATA_W'(1);
            end
        end
    end

    assign run_o   = run_q;
    assign auto_o  = auto_q;
    assign load_o  = load_q;
    assign count_o = count_q;
endmodule

// File: rtl/timer_irq_ctl.sv
// Sticky overflow flag with one-write-to-clear and an interrupt enable.
// Setting wins over a clear in the same cycle so no event is lost.
module timer_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_i,
    input  logic clr_i,
    input  logic ien_wr_i,
    input  logic ien_data_i,
    output logic flag_o,
    output logic ien_o,
    output logic irq_o
);
    logic flag_q;
    logic ien_q;

    // Overflow flag: set by an event, cleared by a one written to status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (ovf_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    // Interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
        end else if (ien_wr_i) begin
            ien_q <= ien_data_i;
        end
    end

    assign flag_o = flag_q;
    assign ien_o  = ien_q;
    assign irq_o  = flag_q && ien_q;
endmodule

// File: rtl/up_event_timer.sv
// Top of the overflow event timer. It decodes the register bus, routes
// control/reload/count writes through posted slots, and muxes read data.
// Assumes single-cycle bus accesses; reads are combinational on req_addr.
module up_event_timer #(
    parameter int DATA_W   = 32,
    parameter int SYNC_DLY = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic                              req_write,
    input  logic [evt_timer_pkg::ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]                 req_wdata,
    output logic [DATA_W-1:0]                 req_rdata,
    output logic                              irq
);
    import evt_timer_pkg::*;

    logic                  wr_en;
    logic [NUM_SLOTS-1:0]  slot_wr;
    logic [NUM_SLOTS-1:0]  slot_apply;
    logic [NUM_SLOTS-1:0]  slot_pend;
    logic [DATA_W-1:0]     slot_data [NUM_SLOTS];
    logic                  posted_q;
    logic                  run_q;
    logic                  auto_q;
    logic [DATA_W-1:0]     load_q;
    logic [DATA_W-1:0]     count_q;
    logic                  ovf;
    logic                  flag_q;
    logic                  ien_q;

    assign wr_en = req_valid && req_write;

    // One posted slot per timer-domain register (offsets 0..NUM_SLOTS-1).
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign slot_wr[i] = wr_en && (req_addr == ADDR_W'(i));

        timer_post_slot #(
            .DATA_W   (DATA_W),
            .SYNC_DLY (SYNC_DLY)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .posted_i (posted_q),
            .wr_i     (slot_wr[i]),
            .wdata_i  (req_wdata),
            .apply_o  (slot_apply[i]),
            .data_o   (slot_data[i]),
            .pend_o   (slot_pend[i])
        );
    end

    // Posted-mode select; always written directly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            posted_q <= 1'b0;
        end else if (wr_en && req_addr == REG_MODE) begin
            posted_q <= req_wdata[0];
        end
    end

    timer_counter #(
        .DATA_W (DATA_W)
    ) u_counter (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_apply_i  (slot_apply[SLOT_CTRL]),
        .ctrl_data_i   (slot_data[SLOT_CTRL]),
        .load_apply_i  (slot_apply[SLOT_LOAD]),
        .load_data_i   (slot_data[SLOT_LOAD]),
        .count_apply_i (slot_apply[SLOT_COUNT]),
        .count_data_i  (slot_data[SLOT_COUNT]),
        .run_o         (run_q),
        .auto_o        (auto_q),
        .load_o        (load_q),
        .count_o       (count_q),
        .ovf_o         (ovf)
    );

    timer_irq_ctl u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovf_i      (ovf),
        .clr_i      (wr_en && req_addr == REG_STAT && req_wdata[0]),
        .ien_wr_i   (wr_en && req_addr == REG_IEN),
        .ien_data_i (req_wdata[0]),
        .flag_o     (flag_q),
        .ien_o      (ien_q),
        .irq_o      (irq)
    );

    // Read data mux over the register offsets.
    always_comb begin
        req_rdata = '0;
        case (req_addr)
            REG_CTRL:  begin
                req_rdata[CTRL_RUN_BIT]  = run_q;
                req_rdata[CTRL_AUTO_BIT] = auto_q;
            end
            REG_LOAD:  req_rdata = load_q;
            REG_COUNT: req_rdata = count_q;
            REG_STAT:  req_rdata[0] = flag_q;
            REG_IEN:   req_rdata[0] = ien_q;
            REG_PEND:  req_rdata[NUM_SLOTS-1:0] = slot_pend;
            REG_MODE:  req_rdata[0] = posted_q;
            default:   req_rdata = '0;
        endcase
    end
endmodule

// File: rtl/up_event_timer_chk.sv
// Assertion checker for up_event_timer, attached by bind below.
module up_event_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              auto_rl,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] load,
    input logic              flag,
    input logic              count_apply,
    input logic              ctrl_apply,
    input logic              posted,
    input logic              ctrl_wr,
    input logic [2:0]        pend
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && count != {DATA_W{1'b1}} && !count_apply |=> count == $past(count) + DATA_W'(1)); // R1

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !count_apply |=> $stable(count)); // R1

    AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        run && auto_rl && count == {DATA_W{1'b1}} && !count_apply
        |=> count == $past(load) && flag); // R3

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        run && !auto_rl && count == {DATA_W{1'b1}} && !count_apply && !ctrl_apply
        |=> !run && count == '0 && flag); // R4

    AST_FLAG_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(run)); // R9

    AST_POSTED_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        posted && ctrl_wr |=> pend[0]); // R5
endmodule

bind up_event_timer up_event_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run_q),
    .auto_rl     (auto_q),
    .count       (count_q),
    .load        (load_q),
    .flag        (flag_q),
    .count_apply (slot_apply[evt_timer_pkg::SLOT_COUNT]),
    .ctrl_apply  (slot_apply[evt_timer_pkg::SLOT_CTRL]),
    .posted      (posted_q),
    .ctrl_wr     (slot_wr[evt_timer_pkg::SLOT_CTRL]),
    .pend        (slot_pend)
);

// File: tb/up_event_timer_test.sv
module up_event_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    // Entry: {is_write, addr[2:0], data/expected[31:0]}; all in direct mode, counter stopped.
    localparam logic [35:0] VEC [NV] = '{
        {1'b1, 3'd4, 32'h1},          // enable on
        {1'b0, 3'd4, 32'h1},          // R7 enable takes effect at once
        {1'b1, 3'd1, 32'h1234},
        {1'b0, 3'd1, 32'h1234},       // R6 direct reload write
        {1'b0, 3'd5, 32'h0},          // R6 nothing pending
        {1'b1, 3'd2, 32'h55},
        {1'b0, 3'd2, 32'h55},         // R6 direct count write
        {1'b1, 3'd3, 32'h1},
        {1'b0, 3'd3, 32'h0},          // R7 clearing an already-clear flag
        {1'b1, 3'd0, 32'h2},
        {1'b0, 3'd0, 32'h2},          // R3 periodic bit alone, not running
        {1'b0, 3'd2, 32'h55},         // R1 stopped count holds
        {1'b1, 3'd4, 32'h0},
        {1'b0, 3'd4, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_rdata;
    logic        irq;
    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    up_event_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_rdata (req_rdata),
        .irq       (irq)
    );

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_reg(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_addr = a;
        #1;
        check_val(tag, req_rdata, exp);
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        req_addr = a;
        #1;
        v = req_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] v1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        for (int a = 0; a < 7; a++) check_reg(3'(a), 32'h0, "R2 register after reset");
        check_val("R2 irq after reset", {31'b0, irq}, 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][35]) bus_write(VEC[i][34:32], VEC[i][31:0]);
            else check_reg(VEC[i][34:32], VEC[i][31:0], $sformatf("R6/R7 table entry %0d", i));
        end

        // R1 counting and holding
        bus_write(3'd2, 32'd100);
        bus_write(3'd0, 32'h1);
        repeat (5) @(posedge clk);
        check_reg(3'd2, 32'd105, "R1 count after 5 edges");
        bus_write(3'd0, 32'h0);
        read_reg(3'd2, v1);
        repeat (5) @(posedge clk);
        check_reg(3'd2, v1, "R1 stopped count holds");

        // R4 one-shot, R10 tick count, R8 irq
        bus_write(3'd4, 32'h1);
        bus_write(3'd2, 32'hFFFF_FFFB);
        bus_write(3'd0, 32'h1);
        repeat (4) @(posedge clk);
        check_reg(3'd2, 32'hFFFF_FFFF, "R10 count at all-ones before wrap");
        check_val("R10 no irq before wrap", {31'b0, irq}, 32'h0);
        @(posedge clk);
        check_reg(3'd3, 32'h1, "R10 flag on N+1th edge");
        check_val("R8 irq with flag and enable", {31'b0, irq}, 32'h1);
        check_reg(3'd2, 32'h0, "R4 count zero after one-shot wrap");
        check_reg(3'd0, 32'h0, "R4 run self-cleared");
        bus_write(3'd4, 32'h0);
        check_val("R8 irq masked by enable", {31'b0, irq}, 32'h0);
        bus_write(3'd4, 32'h1);
        bus_write(3'd3, 32'h0);
        check_reg(3'd3, 32'h1, "R7 writing zero keeps flag");
        bus_write(3'd3, 32'h1);
        check_reg(3'd3, 32'h0, "R7 write one clears flag");
        check_val("R8 irq low after clear", {31'b0, irq}, 32'h0);

        // R3 periodic reload
        bus_write(3'd1, 32'hFFFF_FFFD);
        bus_write(3'd2, 32'hFFFF_FFFD);
        bus_write(3'd0, 32'h3);
        repeat (3) @(posedge clk);
        check_reg(3'd2, 32'hFFFF_FFFD, "R3 count reloaded on wrap");
        check_reg(3'd3, 32'h1, "R3 flag on periodic wrap");
        check_reg(3'd0, 32'h3, "R3 still running");
        bus_write(3'd0, 32'h0);
        bus_write(3'd3, 32'h1);

        // R9 stop before overflow
        bus_write(3'd2, 32'hFFFF_FFF0);
        bus_write(3'd0, 32'h1);
        repeat (3) @(posedge clk);
        bus_write(3'd0, 32'h0);
        repeat (20) @(posedge clk);
        check_reg(3'd3, 32'h0, "R9 no flag after early stop");
        check_val("R9 no irq after early stop", {31'b0, irq}, 32'h0);

        // R5 posted write latency and pending flags
        bus_write(3'd6, 32'h1);
        bus_write(3'd1, 32'h0000_ABCD);
        check_reg(3'd5, 32'h2, "R5 reload pending");
        check_reg(3'd1, 32'hFFFF_FFFD, "R5 old reload before landing");
        check_reg(3'd5, 32'h2, "R5 still pending");
        check_reg(3'd1, 32'h0000_ABCD, "R5 reload lands on third edge");
        check_reg(3'd5, 32'h0, "R5 pending cleared");

        // R5/R10 posted one-shot timing
        bus_write(3'd2, 32'hFFFF_FFFC);
        bus_write(3'd0, 32'h1);
        check_reg(3'd5, 32'h5, "R5 count and control pending");
        repeat (6) @(posedge clk);
        check_reg(3'd2, 32'hFFFF_FFFF, "R10 posted count at all-ones");
        @(posedge clk);
        check_reg(3'd3, 32'h1, "R10 posted flag timing");
        check_reg(3'd0, 32'h0, "R4 posted one-shot halts");
        bus_write(3'd3, 32'h1);

        // R11 rewrite while pending restarts delay
        bus_write(3'd1, 32'h10);
        bus_write(3'd1, 32'h20);
        repeat (2) @(posedge clk);
        check_reg(3'd1, 32'h0000_ABCD, "R11 nothing landed three edges after first write");
        check_reg(3'd1, 32'h20, "R11 second value lands");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule